// File: doc/BRIEF.md
# Three-Line Monitor Sense Sequencer

This block works out which kind of display is attached by probing three monitor identification lines, called A, B and C. Each line has an open-drain style driver with an enable and a value. It is pulled high when it is not driven, and the attached monitor may tie lines to ground or short lines to each other. A single-cycle start pulse launches a fixed sequence:

1. All three lines are driven high for a short interval.
2. All drivers are released, and the lines are left to settle for a long interval.
3. Each line in turn is then pulled low while the other two are observed.

Every observation is taken at the end of its settle interval from a two-flop synchronized copy of the line inputs. The observations are packed into an 11-bit sense code.

When the last observation is stored, the done flag rises, all drivers are released and the code is held. The flag stays up until the next start pulse. A start pulse that arrives during the sequence is ignored. Turning the code into a display mode is left to the consumer.

Top module: `monitor_sense_seq`

## Requirements
- R1: After reset, `done_o` is 0, `code_o` is 0, and both `drv_en_o` and `drv_val_o` are 0 (all lines released).
- R2: A start pulse accepted while idle or done drives all lines high (`drv_en_o`=111, `drv_val_o`=111) for exactly `SHORT_CYC` cycles.
- R3: After the drive-high interval, all drivers are released (`drv_en_o`=000) for a settle interval of 10×`SHORT_CYC` cycles.
- R4: At the end of the released interval the synchronized levels are stored as code bit 10 = C, bit 9 = B and bit 8 = A.
- R5: Next, for 10×`SHORT_CYC` cycles, only line A is driven low (`drv_en_o`=001, `drv_val_o`=000). At the end of that interval code bit 5 = B and bit 4 = C.
- R6: Next, for 10×`SHORT_CYC` cycles, only line B is driven low (`drv_en_o`=010). At the end of that interval code bit 3 = C and bit 2 = A.
- R7: Next, for 10×`SHORT_CYC` cycles, only line C is driven low (`drv_en_o`=100). At the end of that interval code bit 1 = A and bit 0 = B.
- R8: Code bits 7:6 are always 0.
- R9: `done_o` rises exactly `SHORT_CYC`+40×`SHORT_CYC` clock edges after the edge that accepts start. At that point all drivers are released. `done_o` and `code_o` then hold, whatever the lines do, until the next start pulse, which clears `done_o`.
- R10: A start pulse that arrives while the sequence is running has no effect on the drive schedule, on the time at which done rises, or on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to run the sequence |
| line_i | input | 3 | Sensed line levels; bit 0 = A, bit 1 = B, bit 2 = C |
| drv_en_o | output | 3 | Per-line driver enable, same bit order as `line_i` |
| drv_val_o | output | 3 | Level driven on an enabled line |
| done_o | output | 1 | Sense code valid; held until the next start |
| code_o | output | 11 | Assembled sense code |

## Verification
The assertions take two things for granted:
- `start_i` is a clean synchronous pulse.
- The line levels reach their final value well within one settle interval after the drivers change, so that the synchronizer delay never hides the level being observed.

The bench keeps within these limits. It models the monitor as a combinational network: lines can be grounded or linked, and a line reads low if anything on its net is low. The bench sets the network only while the block is idle or done, and uses settle intervals many cycles longer than the two-flop delay. All 64 combinations of grounded lines and links are swept. Some runs inject a start pulse in the middle of the sequence.

// File: rtl/msense_pkg.sv
package msense_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HIGH,
        PH_FLOAT,
        PH_LOW_A,
        PH_LOW_B,
        PH_LOW_C,
        PH_DONE
    } phase_e;

    localparam int NUM_LINES = 3;
    localparam int CODE_W    = 11;

endpackage

// File: rtl/msense_sync.sv
module msense_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/msense_timer.sv
module msense_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)             cnt_d = len_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3: an unloaded running interval counts down by exactly one per cycle
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/monitor_sense_seq.sv
module monitor_sense_seq
    import msense_pkg::*;
#(
    parameter int SHORT_CYC = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_LINES-1:0] line_i,
    output logic [NUM_LINES-1:0] drv_en_o,
    output logic [NUM_LINES-1:0] drv_val_o,
    output logic                 done_o,
    output logic [CODE_W-1:0]    code_o
);
    localparam int LONG_CYC = 10 * SHORT_CYC;
    localparam int CW       = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_LEN = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_LEN  = CW'(LONG_CYC - 1);

    localparam int LA = 0;
    localparam int LB = 1;
    localparam int LC = 2;

    typedef struct packed {
        phase_e              ph;
        logic [CODE_W-1:0]   code;
        logic                done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [NUM_LINES-1:0] lvl;
    logic                 tmr_load;
    logic [CW-1:0]        tmr_len;
    logic                 tmr_zero;

    msense_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_i),
        .sync_o  (lvl)
    );

    msense_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .zero_o (tmr_zero)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_len  = LONG_LEN;
        unique case (seq_q.ph)
            PH_IDLE, PH_DONE: begin
                if (start_i) begin
                    seq_d.ph   = PH_HIGH;
                    seq_d.code = '0;
                    seq_d.done = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_len    = SHORT_LEN;
                end
            end
            PH_HIGH: begin
                if (tmr_zero) begin
                    seq_d.ph = PH_FLOAT;
                    tmr_load = 1'b1;
                end
            end
            PH_FLOAT: begin
                if (tmr_zero) begin
                    seq_d.code[10] = lvl[LC];
                    seq_d.code[9]  = lvl[LB];
                    seq_d.code[8]  = lvl[LA];
                    seq_d.ph       = PH_LOW_A;
                    tmr_load       = 1'b1;
                end
            end
            PH_LOW_A: begin
                if (tmr_zero) begin
                    seq_d.code[5] = lvl[LB];
                    seq_d.code[4] = lvl[LC];
                    seq_d.ph      = PH_LOW_B;
                    tmr_load      = 1'b1;
                end
            end
            PH_LOW_B: begin
                if (tmr_zero) begin
                    seq_d.code[3] = lvl[LC];
                    seq_d.code[2] = lvl[LA];
                    seq_d.ph      = PH_LOW_C;
                    tmr_load      = 1'b1;
                end
            end
            PH_LOW_C: begin
                if (tmr_zero) begin
                    seq_d.code[1] = lvl[LA];
                    seq_d.code[0] = lvl[LB];
                    seq_d.ph      = PH_DONE;
                    seq_d.done    = 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.ph   <= PH_IDLE;
            seq_q.code <= '0;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        drv_en_o  = '0;
        drv_val_o = '0;
        unique case (seq_q.ph)
            PH_HIGH: begin
                drv_en_o  = '1;
                drv_val_o = '1;
            end
            PH_LOW_A: drv_en_o[LA] = 1'b1;
            PH_LOW_B: drv_en_o[LB] = 1'b1;
            PH_LOW_C: drv_en_o[LC] = 1'b1;
            default: ;
        endcase
    end

    assign done_o = seq_q.done;
    assign code_o = seq_q.code;

    // R5 R6 R7: outside the drive-high phase, at most one line is driven and it is driven low
    a_r5_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o != 3'b111) |-> ($onehot0(drv_en_o) && drv_val_o == 3'b000));

    // R9: done only rises straight after the line-C-low phase
    a_r9_done_after_c: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(drv_en_o) == 3'b100));

    // R9: while done, every driver is released
    a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (drv_en_o == 3'b000));

    // R9: done and code hold until a start pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(code_o)));

    // R2: a start while done clears done on the next edge
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && drv_en_o == 3'b111));
endmodule

// File: tb/monitor_sense_seq_test.sv
module monitor_sense_seq_test;
    localparam int SHORT = 3;
    localparam int LONG  = 10 * SHORT;
    localparam int TOTAL = SHORT + 4 * LONG;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  line;
    logic [2:0]  drv_en, drv_val;
    logic        done;
    logic [10:0] code;
    logic [2:0]  gnd_s = 3'b000;
    logic [2:0]  lk_s  = 3'b000;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    monitor_sense_seq #(.SHORT_CYC(SHORT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .line_i    (line),
        .drv_en_o  (drv_en),
        .drv_val_o (drv_val),
        .done_o    (done),
        .code_o    (code)
    );

    // Monitor model: bit 0 = A, 1 = B, 2 = C; lk[0]=A-B, lk[1]=B-C, lk[2]=C-A
    function automatic logic [2:0] lvl(input logic [2:0] en, input logic [2:0] val,
                                       input logic [2:0] gnd, input logic [2:0] lk);
        logic [2:0] b;
        logic [2:0] r;
        logic c01, c12, c20;
        for (int i = 0; i < 3; i++) b[i] = gnd[i] ? 1'b0 : (en[i] ? val[i] : 1'b1);
        c01 = lk[0] | (lk[1] & lk[2]);
        c12 = lk[1] | (lk[0] & lk[2]);
        c20 = lk[2] | (lk[0] & lk[1]);
        r[0] = b[0] & (c01 ? b[1] : 1'b1) & (c20 ? b[2] : 1'b1);
        r[1] = b[1] & (c01 ? b[0] : 1'b1) & (c12 ? b[2] : 1'b1);
        r[2] = b[2] & (c12 ? b[1] : 1'b1) & (c20 ? b[0] : 1'b1);
        return r;
    endfunction

    always_comb line = lvl(drv_en, drv_val, gnd_s, lk_s);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_drive(input int n);
        if (n < SHORT)                return 6'b111_111;
        else if (n < SHORT + LONG)    return 6'b000_000;
        else if (n < SHORT + 2*LONG)  return 6'b001_000;
        else if (n < SHORT + 3*LONG)  return 6'b010_000;
        else                          return 6'b100_000;
    endfunction

    function automatic string drive_tag(input int n);
        if (n < SHORT)                return "R2 drive-high";
        else if (n < SHORT + LONG)    return "R3 released";
        else if (n < SHORT + 2*LONG)  return "R5 A-low";
        else if (n < SHORT + 3*LONG)  return "R6 B-low";
        else                          return "R7 C-low";
    endfunction

    task automatic run_cfg(input int cfg, input bit inject);
        logic [2:0]  rel, pa, pb, pc;
        logic [10:0] exp;
        logic [10:0] held;
        gnd_s = cfg[2:0];
        lk_s  = cfg[5:3];
        rel = lvl(3'b000, 3'b000, gnd_s, lk_s);
        pa  = lvl(3'b001, 3'b000, gnd_s, lk_s);
        pb  = lvl(3'b010, 3'b000, gnd_s, lk_s);
        pc  = lvl(3'b100, 3'b000, gnd_s, lk_s);
        exp = {rel[2], rel[1], rel[0], 2'b00, pa[1], pa[2], pb[2], pb[0], pc[0], pc[1]};
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < TOTAL; n++) begin
            chk(drive_tag(n), {26'd0, drv_en, drv_val}, {26'd0, exp_drive(n)});
            chk(inject ? "R10 done early" : "R9 done early", {31'd0, done}, 32'd0);
            start = (inject && n == SHORT + 5) ? 1'b1 : 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        chk(inject ? "R10 done latency" : "R9 done latency", {31'd0, done}, 32'd1);
        chk("R9 released at done", {29'd0, drv_en}, 32'd0);
        chk("R4 bits 10:8", {29'd0, code[10:8]}, {29'd0, exp[10:8]});
        chk("R5 bits 5:4", {30'd0, code[5:4]}, {30'd0, exp[5:4]});
        chk("R6 bits 3:2", {30'd0, code[3:2]}, {30'd0, exp[3:2]});
        chk("R7 bits 1:0", {30'd0, code[1:0]}, {30'd0, exp[1:0]});
        chk("R8 bits 7:6", {30'd0, code[7:6]}, 32'd0);
        held = code;
        gnd_s = ~gnd_s;
        repeat (6) @(negedge clk);
        chk("R9 hold done", {31'd0, done}, 32'd1);
        chk("R9 hold code", {21'd0, code}, {21'd0, held});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done reset", {31'd0, done}, 32'd0);
        chk("R1 code reset", {21'd0, code}, 32'd0);
        chk("R1 drivers reset", {26'd0, drv_en, drv_val}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int cfg = 0; cfg < 64; cfg++) run_cfg(cfg, (cfg % 3) == 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule